// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small processor core and decides when execution is diverted to an interrupt handler. It serves 21 numbered sources. Source 1 is the reset request. A group of external pins comes next, each with its own edge or level detector. The remaining sources are on-chip peripheral requests. Each source has a pending flag. An event-type flag latches its event and holds it until it is serviced or cleared. A condition-type flag simply mirrors its input.

The core reports every completed instruction on `instr_done` and every return-from-handler on `reti_strobe`. When a boundary arrives and an eligible source is pending, the block does three things on the next clock. It pulses `take` and `push_pc` together. It presents the handler word address on `vec_addr`. It drops the global enable. The core then pushes its PC and jumps. A return sets the global enable again, but the first boundary after a return is always let through, so at least one instruction of the interrupted program runs before the next handler is entered.

Source numbering and source index: source k sits at bit k-1 of every per-source vector. Bit 0 is the reset source. Bits 1..NUM_PINS are the external pins. The bits above them are peripherals. With the default parameters, peripheral j sits at bit 4+j. Peripherals 13..16 (bits 17..20) are condition type and the rest are event type.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `take`, `push_pc`, `gie`, `vec_addr` and every bit of `pend` read 0.
- R2: When several eligible sources are pending at the same boundary, the lowest-numbered source (lowest bit index) is the one taken.
- R3: When source k is taken, `vec_addr` equals 2*(k-1). Bit 0 maps to 0x00, bit 1 to 0x02, and bit 20 to 0x28.
- R4: The reset source (bit 0) is taken at the next boundary whenever its flag is set, whatever the global enable, its enable bit, or the post-return hold.
- R5: Any other source is taken only if `gie` is 1, its `src_en` bit is 1 and its `pend` bit is 1. A source that is masked stays pending.
- R6: A take happens only on a cycle in which `instr_done` is 1. `take` and `push_pc` are high for exactly the one cycle that follows, and `gie` reads 0 in that cycle.
- R7: A cycle with `reti_strobe` high sets `gie` to 1 on the next clock. The first `instr_done` cycle at or after that return takes no non-reset source. A later boundary may take one.
- R8: An event-type flag sets on its event even while `gie` is 0, and it stays set until it is cleared.
- R9: A 1 in `flag_w1c` clears the matching event-type flag on the next clock. It has no effect on a condition-type flag.
- R10: A condition-type flag follows its input one clock later. If the condition ends before the source is enabled, the flag drops and nothing is taken. Taking a condition-type source does not clear its flag.
- R11: Each pin has a 2-bit field `pin_mode[2p+1:2p]`: 00 = pin low (condition type), 01 = any change, 10 = falling edge, 11 = rising edge. A pin change shows in `pend` on the third clock after the change.
- R12: The event flag of the source being taken reads 0 in the same cycle that `take` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Core finished an instruction this cycle |
| reti_strobe | input | 1 | Core executed a return from handler |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| src_en | input | NUM_SRC | Per-source enable (bit 0 is ignored) |
| flag_w1c | input | NUM_SRC | Write-1-to-clear strobes for event flags |
| rst_req | input | 1 | Reset-source request |
| pin_in | input | NUM_PINS | Asynchronous external pins |
| pin_mode | input | 2*NUM_PINS | Sense select, two bits per pin |
| per_req | input | NUM_PER | Peripheral request lines |
| take | output | 1 | One-cycle interrupt-taken pulse |
| push_pc | output | 1 | Request to push the PC |
| vec_addr | output | ADDR_W | Handler word address |
| gie | output | 1 | Global interrupt enable |
| pend | output | NUM_SRC | Pending flags |

## Verification
A flag that is wrongly latched or lost shows on `pend` one clock after the stimulus. For pins it shows three clocks after the change. It also shows at the next boundary, as a take that should not happen or a take that is missing. An arbiter or vector fault shows on `vec_addr` in the very cycle `take` rises. A stuck post-return hold or a stuck global enable shows within the two boundaries that follow a return. That return sequence, the mixed-type priority table and every pin sense mode are driven so that each of these faults reaches the ports within a few clocks.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pin,
  input  irq_pkg::sense_e mode,
  output logic            hit,
  output logic            is_level,
  output logic            level_on
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  // Synchronizer chain; idle-high reset so a quiet pin raises nothing.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];

  always_comb begin
    hit      = 1'b0;
    is_level = 1'b0;
    level_on = ~cur;
    unique case (mode)
      irq_pkg::SENSE_LOW:  is_level = 1'b1;
      irq_pkg::SENSE_ANY:  hit = cur ^ prev_q;
      irq_pkg::SENSE_FALL: hit = prev_q & ~cur;
      irq_pkg::SENSE_RISE: hit = cur & ~prev_q;
      default:             hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic is_cond,
  input  logic cond_val,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);
  // Condition flags mirror their input; event flags latch, set beats clear.
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (is_cond) flag <= cond_val;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N     = 21,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Fixed priority: lowest index wins.
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC     = 21,
  parameter int NUM_PINS    = 3,
  parameter int NUM_PER     = NUM_SRC - 1 - NUM_PINS,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_PER-1:0] PER_COND_MASK = 'h1E000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  instr_done,
  input  logic                  reti_strobe,
  input  logic                  gie_set,
  input  logic                  gie_clr,
  input  logic [NUM_SRC-1:0]    src_en,
  input  logic [NUM_SRC-1:0]    flag_w1c,
  input  logic                  rst_req,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic [2*NUM_PINS-1:0] pin_mode,
  input  logic [NUM_PER-1:0]    per_req,
  output logic                  take,
  output logic                  push_pc,
  output logic [ADDR_W-1:0]     vec_addr,
  output logic                  gie,
  output logic [NUM_SRC-1:0]    pend
);
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int PIN_BASE = 1;
  localparam int PER_BASE = 1 + NUM_PINS;

  logic [NUM_SRC-1:0] s_is_cond, s_cond, s_set, s_clr, s_take_clr, elig;
  logic               hold_q;
  logic               win_any, fire;
  logic [IDX_W-1:0]   win_idx;

  // Reset source: event type, fed by the request line.
  assign s_is_cond[0] = 1'b0;
  assign s_cond[0]    = 1'b0;
  assign s_set[0]     = rst_req;

  // External pins.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit, is_lvl, lvl_on;
    irq_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk      (clk),
      .rst      (rst),
      .pin      (pin_in[p]),
      .mode     (irq_pkg::sense_e'(pin_mode[2*p +: 2])),
      .hit      (hit),
      .is_level (is_lvl),
      .level_on (lvl_on)
    );
    assign s_is_cond[PIN_BASE+p] = is_lvl;
    assign s_cond[PIN_BASE+p]    = lvl_on;
    assign s_set[PIN_BASE+p]     = hit;
  end

  // Peripheral requests, type chosen per source by parameter.
  for (genvar j = 0; j < NUM_PER; j++) begin : g_per
    if (PER_COND_MASK[j]) begin : g_cond
      assign s_is_cond[PER_BASE+j] = 1'b1;
      assign s_cond[PER_BASE+j]    = per_req[j];
      assign s_set[PER_BASE+j]     = 1'b0;
    end else begin : g_evt
      assign s_is_cond[PER_BASE+j] = 1'b0;
      assign s_cond[PER_BASE+j]    = 1'b0;
      assign s_set[PER_BASE+j]     = per_req[j];
    end
  end

  // Flag bank and eligibility.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    assign s_take_clr[i] = fire && (win_idx == IDX_W'(i));
    assign s_clr[i]      = s_take_clr[i] | flag_w1c[i];
    irq_flag_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .is_cond  (s_is_cond[i]),
      .cond_val (s_cond[i]),
      .set_evt  (s_set[i]),
      .clr      (s_clr[i]),
      .flag     (pend[i])
    );
    if (i == 0) begin : g_rst_elig
      assign elig[i] = pend[i];
    end else begin : g_src_elig
      assign elig[i] = pend[i] & src_en[i] & gie & ~hold_q & ~reti_strobe;
    end
  end

  irq_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .req (elig),
    .any (win_any),
    .idx (win_idx)
  );

  assign fire = instr_done & win_any;

  // Global enable, post-return hold and registered take outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      gie      <= 1'b0;
      hold_q   <= 1'b0;
      take     <= 1'b0;
      push_pc  <= 1'b0;
      vec_addr <= '0;
    end else begin
      take    <= fire;
      push_pc <= fire;
      if (fire) vec_addr <= ADDR_W'({win_idx, 1'b0});

      if (fire)                       gie <= 1'b0;
      else if (reti_strobe | gie_set) gie <= 1'b1;
      else if (gie_clr)               gie <= 1'b0;

      if (reti_strobe)     hold_q <= 1'b1;
      else if (instr_done) hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_checker.sv
module prio_irq_ctrl_checker #(
  parameter int NUM_SRC = 21,
  parameter int ADDR_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               instr_done,
  input logic               reti_strobe,
  input logic               rst_req,
  input logic               take,
  input logic               push_pc,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic               gie,
  input logic [NUM_SRC-1:0] pend
);
  localparam logic [ADDR_W-1:0] LAST_VEC = ADDR_W'(2 * (NUM_SRC - 1));

  p_take_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(instr_done));

  p_gie_off_on_take_r6: assert property (@(posedge clk) disable iff (rst)
    take |-> (!gie && push_pc));

  p_vec_range_r3: assert property (@(posedge clk) disable iff (rst)
    take |-> (vec_addr[0] == 1'b0 && vec_addr <= LAST_VEC));

  p_needs_gie_r5: assert property (@(posedge clk) disable iff (rst)
    (take && vec_addr != '0) |-> $past(gie));

  p_reti_enables_r7: assert property (@(posedge clk) disable iff (rst)
    reti_strobe |=> (gie || take));

  p_reti_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (reti_strobe && !pend[0]) |=> !take);

  p_reset_flag_cleared_r12: assert property (@(posedge clk) disable iff (rst)
    (take && vec_addr == '0 && !$past(rst_req)) |-> !pend[0]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int NS = 21;
  localparam int NP = 3;
  localparam int NQ = NS - 1 - NP;
  localparam int AW = 16;
  localparam int NV = 8;
  localparam logic [5:0] NO_TAKE = 6'h3F;

  // Peripheral event pulses, enables, expected vector (NO_TAKE = none).
  localparam logic [NQ-1:0] T_EVT [NV] = '{17'h00021, 17'h00088, 17'h00004, 17'h01000,
                                           17'h01002, 17'h00000, 17'h00A10, 17'h00040};
  localparam logic [NS-1:0] T_EN  [NV] = '{21'h1FFFFF, 21'h000800, 21'h000000, 21'h1FFFFF,
                                           21'h1FFFDF, 21'h1FFFFF, 21'h00A000, 21'h1FFFFF};
  localparam logic [5:0]    T_VEC [NV] = '{6'd8, 6'd22, NO_TAKE, 6'd32,
                                           6'd32, NO_TAKE, 6'd26, 6'd20};

  logic clk = 0, rst = 1;
  logic instr_done = 0, reti_strobe = 0, gie_set = 0, gie_clr = 0, rst_req = 0;
  logic [NS-1:0] src_en = '0, flag_w1c = '0;
  logic [NP-1:0] pin_in = '1;
  logic [2*NP-1:0] pin_mode = '0;
  logic [NQ-1:0] per_req = '0;
  logic take, push_pc, gie;
  logic [AW-1:0] vec_addr;
  logic [NS-1:0] pend;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .instr_done(instr_done), .reti_strobe(reti_strobe),
    .gie_set(gie_set), .gie_clr(gie_clr), .src_en(src_en), .flag_w1c(flag_w1c),
    .rst_req(rst_req), .pin_in(pin_in), .pin_mode(pin_mode), .per_req(per_req),
    .take(take), .push_pc(push_pc), .vec_addr(vec_addr), .gie(gie), .pend(pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic boundary();
    instr_done = 1; @(negedge clk); instr_done = 0;
  endtask

  task automatic pulse_gie_set(); gie_set = 1; @(negedge clk); gie_set = 0; endtask
  task automatic pulse_gie_clr(); gie_clr = 1; @(negedge clk); gie_clr = 0; endtask
  task automatic clear_all(); flag_w1c = '1; @(negedge clk); flag_w1c = '0; endtask
  task automatic pulse_per(input logic [NQ-1:0] m); per_req = m; @(negedge clk); per_req = '0; endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst = 0;
    @(negedge clk);
    chk("R1 take", take, 0);
    chk("R1 push", push_pc, 0);
    chk("R1 gie", gie, 0);
    chk("R1 vec", vec_addr, 0);
    chk("R1 pend", pend, 0);

    // Table walk: R2 priority, R3 vector, R5 masking, R8 latch, R12 clear-on-take.
    for (int i = 0; i < NV; i++) begin
      logic [NS-1:0] exp_p;
      clear_all();
      src_en = T_EN[i];
      pulse_per(T_EVT[i]);
      pulse_gie_set();
      exp_p = {T_EVT[i], 4'b0000};
      chk("R8 latched", pend, exp_p);
      boundary();
      if (T_VEC[i] == NO_TAKE) begin
        chk("R5 masked no take", take, 0);
        chk("R5 still pending", pend, exp_p);
      end else begin
        chk("R2 take", take, 1);
        chk("R3 vector", vec_addr, AW'(T_VEC[i]));
        chk("R12 flag cleared", pend, exp_p & ~(NS'(1) << (T_VEC[i] / 2)));
        chk("R6 gie cleared", gie, 0);
      end
      pulse_gie_clr();
    end

    // R6: no take without a boundary; one-cycle pulses.
    clear_all();
    src_en = '1;
    pulse_per(17'h00001);
    pulse_gie_set();
    for (int k = 0; k < 3; k++) begin
      chk("R6 no boundary", take, 0);
      @(negedge clk);
    end
    boundary();
    chk("R6 take", take, 1);
    chk("R6 push", push_pc, 1);
    chk("R3 vec src5", vec_addr, 8);
    @(negedge clk);
    chk("R6 take pulse width", take, 0);
    chk("R6 push pulse width", push_pc, 0);

    // R7/R8: event latched in handler, return then one-instruction hold.
    pulse_per(17'h00002);
    chk("R8 latched gie off", pend[5], 1);
    boundary();
    chk("R5 no take gie off", take, 0);
    reti_strobe = 1; @(negedge clk); reti_strobe = 0;
    chk("R7 gie set", gie, 1);
    boundary();
    chk("R7 hold after return", take, 0);
    boundary();
    chk("R7 take after hold", take, 1);
    chk("R7 vec src6", vec_addr, 10);

    // R4: reset source ignores all enables.
    pulse_gie_clr();
    src_en = '0;
    rst_req = 1; @(negedge clk); rst_req = 0;
    chk("R4 reset pending", pend[0], 1);
    boundary();
    chk("R4 reset taken", take, 1);
    chk("R4 reset vector", vec_addr, 0);
    chk("R12 reset flag cleared", pend[0], 0);

    // R9: write-1-to-clear on event vs condition flags.
    clear_all();
    pulse_per(17'h00004);
    chk("R9 event set", pend[6], 1);
    flag_w1c[6] = 1; @(negedge clk); flag_w1c = '0;
    chk("R9 event cleared", pend[6], 0);
    per_req[13] = 1; @(negedge clk);
    chk("R10 cond follows", pend[17], 1);
    flag_w1c[17] = 1; @(negedge clk); flag_w1c = '0;
    chk("R9 cond ignores clear", pend[17], 1);

    // R10: condition lost before enable; condition take keeps flag.
    src_en = '1;
    boundary();
    chk("R10 no take gie off", take, 0);
    per_req[13] = 0; @(negedge clk);
    chk("R10 cond dropped", pend[17], 0);
    pulse_gie_set();
    boundary();
    chk("R10 lost condition", take, 0);
    per_req[14] = 1; @(negedge clk);
    boundary();
    chk("R10 cond take", take, 1);
    chk("R10 cond vector", vec_addr, 36);
    chk("R10 cond flag kept", pend[18], 1);
    per_req = '0;
    pulse_gie_clr();

    // R11: pin sense modes and latency.
    clear_all();
    pin_mode = {2'b00, 2'b11, 2'b10};
    pin_in[0] = 0;
    wait_n(2);
    chk("R11 fall latency", pend[1], 0);
    @(negedge clk);
    chk("R11 fall seen", pend[1], 1);
    pin_in[1] = 0;
    wait_n(4);
    chk("R11 rise ignores fall", pend[2], 0);
    pin_in[1] = 1;
    wait_n(3);
    chk("R11 rise seen", pend[2], 1);
    pin_in[2] = 0;
    wait_n(3);
    chk("R11 low level", pend[3], 1);
    pin_in[2] = 1;
    wait_n(3);
    chk("R11 level released", pend[3], 0);
    flag_w1c[1] = 1; @(negedge clk); flag_w1c = '0;
    pin_mode[1:0] = 2'b01;
    pin_in[0] = 1;
    wait_n(3);
    chk("R11 any change up", pend[1], 1);
    flag_w1c[1] = 1; @(negedge clk); flag_w1c = '0;
    chk("R9 pin cleared", pend[1], 0);
    pin_in[0] = 0;
    wait_n(3);
    chk("R11 any change down", pend[1], 1);
    pulse_gie_set();
    boundary();
    chk("R2 pin priority", take, 1);
    chk("R3 pin vector", vec_addr, 2);
    chk("R2 lower kept", pend[2], 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule